// File: doc/BRIEF.md
# Auto-increment word-program sequencer for serial flash

The sequencer writes an arbitrary run of bytes into a serial NOR flash that supports auto-address-increment word programming. A single start pulse supplies the start address, the byte count and a mode bit. Data bytes arrive on a valid/ready stream in address order. The block turns the request into command frames on a byte-level master port and leaves the actual bit shifting to a separate shifter. It checks the flash's busy flag after every program frame by issuing status-read frames. It finishes with a one-cycle done pulse, an error flag and the number of bytes the flash confirmed.

In word mode, a byte at an odd start address is first written with a single-byte program. Pairs of bytes are then written with the auto-increment opcode. Only the first pair carries an address. Auto-increment mode is closed with a write-disable, and a leftover last byte gets its own single-byte program. In byte mode every byte gets its own enable, program and busy wait. One write-disable closes the run.

Top module: `aai_program_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o`, `err_o`, `tx_valid_o` and `in_ready_o` are low and `written_o` is zero.
- R2: Every single-byte program is preceded by its own write-enable frame (one byte 0x06). The program frame is opcode 0x02, three address bytes most significant first, then one data byte. In word mode this form is used for a byte at an odd start address.
- R3: In word mode with at least two bytes at an even address, one write-enable frame is sent first. It is followed by a frame of opcode 0xAD, three address bytes most significant first and two data bytes, lower address first.
- R4: Each later word frame in the same auto-increment run is exactly three bytes: 0xAD and two data bytes, with no address and no write-enable in between.
- R5: After every program frame (0x02 or 0xAD), status-read frames (0x05, 0x00) are repeated until a reply has bit 0 clear. No other frame is sent before that reply.
- R6: When fewer than two bytes remain in auto-increment mode, a one-byte write-disable frame 0x04 is sent before anything else.
- R7: A single byte left over after the word run is written with a single-byte program (R2 form) at the address that follows the last word.
- R8: In byte mode no 0xAD frame is sent. Each byte is written as write-enable, single-byte program and busy wait. One write-disable follows the last byte.
- R9: A status reply that still shows busy once TIMEOUT_CYCLES cycles have passed since the end of the program frame aborts the run. The block then raises `done_o` with `err_o` high, `written_o` holds the bytes confirmed before that frame, and no further frame is sent.
- R10: A successful run ends with a one-cycle `done_o`, `err_o` low, `busy_o` low and `written_o` equal to the requested length. A zero length finishes with no frame.
- R11: Data bytes are taken from the stream only in the data slots of program frames, one per slot and in address order. While a slot waits for data, `tx_valid_o` follows `in_valid_i`.
- R12: A start pulse while a run is in progress is ignored. The frames and the result of the run are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| byte_mode_i | input | 1 | 1: byte program only; 0: auto-increment word mode |
| addr_i | input | ADDR_W | First flash byte address |
| len_i | input | LEN_W | Number of bytes to write |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Last run aborted on timeout |
| written_o | output | LEN_W | Bytes confirmed by the flash |
| in_valid_i | input | 1 | Data stream valid |
| in_byte_i | input | 8 | Data stream byte |
| in_ready_o | output | 1 | Data stream ready |
| tx_valid_o | output | 1 | Command byte valid to shifter |
| tx_byte_o | output | 8 | Command byte |
| tx_last_o | output | 1 | Byte ends the current frame (chip-select release) |
| tx_ready_i | input | 1 | Shifter accepts the byte |
| rx_valid_i | input | 1 | Received byte for the last byte of a frame |
| rx_byte_i | input | 8 | Received byte |

## Verification
The hardest case to reach from the ports is a timeout in the middle of an auto-increment run. To reach it, the flash model in the bench must keep answering busy after one chosen program frame while it stays unaware of the sequencer's inner state. The bench counts program frames as they leave the master port and marks a chosen index as stuck. The expected frame list is then cut right after that frame, which gives the expected confirmed-byte count and data consumption. Random start addresses, lengths, modes, shifter stalls, stream gaps and busy-poll counts cover the parity splits around the word run.

// File: rtl/aai_seq_pkg.sv
// Shared opcodes, frame kinds and controller states for the program sequencer.
package aai_seq_pkg;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_BYTE = 8'h02;
    localparam logic [7:0] OPC_WORD = 8'hAD;

    typedef enum logic [2:0] {
        FR_WREN,
        FR_WRDI,
        FR_RDSR,
        FR_BYTE,
        FR_WFIRST,
        FR_WNEXT
    } frame_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_WREN,
        ST_PROG,
        ST_POLL,
        ST_STAT,
        ST_WRDI
    } seq_state_e;

endpackage

// File: rtl/aai_frame_tx.sv
// Frame emitter: serialises one command frame of a given kind onto the byte
// master port. Data slots pass the input stream straight through.
// Assumes: go_i is only pulsed while idle, and addr_i is stable for the frame.
module aai_frame_tx
    import aai_seq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  frame_e            kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              done_o,
    output logic              tx_valid_o,
    output logic [7:0]        tx_byte_o,
    output logic              tx_last_o,
    input  logic              tx_ready_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_byte_i,
    output logic              in_ready_o
);
    localparam int AB = ADDR_W / 8;

    logic              active_q;
    frame_e            kind_q;
    logic [3:0]        idx_q;
    logic [3:0]        flen;
    logic [3:0]        dstart;
    logic [7:0]        opc;
    logic              data_slot;
    logic [3:0]        sel;
    logic [ADDR_W-1:0] addr_sh;

    // Frame length, first data slot and opcode per frame kind.
    always_comb begin
        flen   = 4'd1;
        dstart = 4'd1;
        opc    = OPC_WREN;
        unique case (kind_q)
            FR_WREN:   begin flen = 4'd1;       dstart = 4'd1;       opc = OPC_WREN; end
            FR_WRDI:   begin flen = 4'd1;       dstart = 4'd1;       opc = OPC_WRDI; end
            FR_RDSR:   begin flen = 4'd2;       dstart = 4'd2;       opc = OPC_RDSR; end
            FR_BYTE:   begin flen = 4'(AB + 2); dstart = 4'(AB + 1); opc = OPC_BYTE; end
            FR_WFIRST: begin flen = 4'(AB + 3); dstart = 4'(AB + 1); opc = OPC_WORD; end
            FR_WNEXT:  begin flen = 4'd3;       dstart = 4'd1;       opc = OPC_WORD; end
            default:   begin flen = 4'd1;       dstart = 4'd1;       opc = OPC_WREN; end
        endcase
    end

    // Byte multiplexer: opcode, address bytes (MSB first), dummy or stream data.
    always_comb begin
        sel       = 4'(AB) - idx_q;
        addr_sh   = addr_i >> {sel, 3'b000};
        data_slot = (idx_q >= dstart) && (idx_q < flen);
        if (idx_q == 4'd0)            tx_byte_o = opc;
        else if (data_slot)           tx_byte_o = in_byte_i;
        else if (kind_q == FR_RDSR)   tx_byte_o = 8'h00;
        else                          tx_byte_o = addr_sh[7:0];
        tx_valid_o = active_q && (data_slot ? in_valid_i : 1'b1);
        in_ready_o = active_q && data_slot && tx_ready_i;
        tx_last_o  = active_q && (idx_q == flen - 4'd1);
        done_o     = tx_valid_o && tx_ready_i && tx_last_o;
    end

    // Frame progress: start on go, step on each accepted byte, stop after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            kind_q   <= FR_WREN;
            idx_q    <= '0;
        end else if (!active_q) begin
            if (go_i) begin
                active_q <= 1'b1;
                kind_q   <= kind_i;
                idx_q    <= '0;
            end
        end else if (tx_valid_o && tx_ready_i) begin
            if (tx_last_o) active_q <= 1'b0;
            else           idx_q    <= idx_q + 4'd1;
        end
    end

endmodule

// File: rtl/aai_wait_timer.sv
// Busy-wait timer: counts cycles while running, saturating at LIMIT.
// Assumes: clear_i is pulsed at the end of each program frame.
module aai_wait_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = (cnt_q == CW'(LIMIT));

    // Saturating cycle count since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (run_i && !expired_o) cnt_q <= cnt_q + CW'(1);
    end

endmodule

// File: rtl/aai_program_seq.sv
// Program sequencer top: splits a byte range into single-byte and
// auto-increment word program frames, with write enable/disable and
// busy polling, and aborts on a busy-wait timeout.
// Assumes: the shifter returns rx_valid_i for the last byte of each status frame.
module aai_program_seq
    import aai_seq_pkg::*;
#(
    parameter int          ADDR_W         = 24,
    parameter int          LEN_W          = 16,
    parameter int          TIMEOUT_CYCLES = 4096,
    parameter logic [7:0]  BUSY_MASK      = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [LEN_W-1:0]  written_o,
    input  logic              in_valid_i,
    input  logic [7:0]        in_byte_i,
    output logic              in_ready_o,
    output logic              tx_valid_o,
    output logic [7:0]        tx_byte_o,
    output logic              tx_last_o,
    input  logic              tx_ready_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_byte_i
);
    seq_state_e        state_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  written_q;
    logic              bmode_q;
    logic              aai_on_q;
    logic              wrdi_due_q;
    frame_e            prog_kind_q;
    logic              go_q;
    frame_e            go_kind_q;
    logic              done_q;
    logic              err_q;
    logic              fe_done;
    logic              tmo_expired;
    logic              flash_busy;
    logic              pick_single;
    logic [1:0]        step;

    aai_frame_tx #(.ADDR_W(ADDR_W)) frame_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go_q),
        .kind_i     (go_kind_q),
        .addr_i     (cur_addr_q),
        .done_o     (fe_done),
        .tx_valid_o (tx_valid_o),
        .tx_byte_o  (tx_byte_o),
        .tx_last_o  (tx_last_o),
        .tx_ready_i (tx_ready_i),
        .in_valid_i (in_valid_i),
        .in_byte_i  (in_byte_i),
        .in_ready_o (in_ready_o)
    );

    aai_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   ((state_q == ST_PROG) && fe_done),
        .run_i     ((state_q == ST_POLL) || (state_q == ST_STAT)),
        .expired_o (tmo_expired)
    );

    // Decode helpers: busy flag of a status reply, next program form, address step.
    always_comb begin
        flash_busy  = |(rx_byte_i & BUSY_MASK);
        pick_single = bmode_q || cur_addr_q[0] || (remain_q == LEN_W'(1));
        step        = (prog_kind_q == FR_BYTE) ? 2'd1 : 2'd2;
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign err_o     = err_q;
    assign written_o = written_q;

    // Run controller: picks the next frame and tracks address, remaining and confirmed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_addr_q  <= '0;
            remain_q    <= '0;
            written_q   <= '0;
            bmode_q     <= 1'b0;
            aai_on_q    <= 1'b0;
            wrdi_due_q  <= 1'b0;
            prog_kind_q <= FR_BYTE;
            go_q        <= 1'b0;
            go_kind_q   <= FR_WREN;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cur_addr_q <= addr_i;
                        remain_q   <= len_i;
                        bmode_q    <= byte_mode_i;
                        written_q  <= '0;
                        err_q      <= 1'b0;
                        aai_on_q   <= 1'b0;
                        wrdi_due_q <= 1'b0;
                        state_q    <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    if (aai_on_q && (remain_q >= LEN_W'(2))) begin
                        prog_kind_q <= FR_WNEXT;
                        go_q        <= 1'b1;
                        go_kind_q   <= FR_WNEXT;
                        state_q     <= ST_PROG;
                    end else if (aai_on_q) begin
                        aai_on_q  <= 1'b0;
                        go_q      <= 1'b1;
                        go_kind_q <= FR_WRDI;
                        state_q   <= ST_WRDI;
                    end else if (remain_q == '0) begin
                        if (wrdi_due_q) begin
                            wrdi_due_q <= 1'b0;
                            go_q       <= 1'b1;
                            go_kind_q  <= FR_WRDI;
                            state_q    <= ST_WRDI;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        prog_kind_q <= pick_single ? FR_BYTE : FR_WFIRST;
                        wrdi_due_q  <= wrdi_due_q | bmode_q;
                        go_q        <= 1'b1;
                        go_kind_q   <= FR_WREN;
                        state_q     <= ST_WREN;
                    end
                end
                ST_WREN: begin
                    if (fe_done) begin
                        go_q      <= 1'b1;
                        go_kind_q <= prog_kind_q;
                        aai_on_q  <= (prog_kind_q == FR_WFIRST);
                        state_q   <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    if (fe_done) begin
                        go_q      <= 1'b1;
                        go_kind_q <= FR_RDSR;
                        state_q   <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (fe_done) state_q <= ST_STAT;
                end
                ST_STAT: begin
                    if (rx_valid_i) begin
                        if (!flash_busy) begin
                            cur_addr_q <= cur_addr_q + ADDR_W'(step);
                            remain_q   <= remain_q - LEN_W'(step);
                            written_q  <= written_q + LEN_W'(step);
                            state_q    <= ST_PLAN;
                        end else if (tmo_expired) begin
                            err_q   <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            go_q      <= 1'b1;
                            go_kind_q <= FR_RDSR;
                            state_q   <= ST_POLL;
                        end
                    end
                end
                ST_WRDI: begin
                    if (fe_done) state_q <= ST_PLAN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/aai_program_seq_chk.sv
// Port-level property checker for the program sequencer, bound to every instance.
module aai_program_seq_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic [LEN_W-1:0] written_o,
    input logic             tx_valid_o,
    input logic             tx_ready_i,
    input logic             in_valid_i,
    input logic             in_ready_o
);
    // R1: an idle block drives nothing onto either port
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!tx_valid_o && !in_ready_o));

    // R10: the end-of-run pulse lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: done is only raised once the block is idle again
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9: an error appears only together with the end of a run
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    // R11: data is taken only while the byte is accepted downstream
    p_stream_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (tx_ready_i && (tx_valid_o == in_valid_i)));

    // R12: the confirmed count never restarts inside a run
    p_count_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (written_o >= $past(written_o)));

endmodule

bind aai_program_seq aai_program_seq_chk #(.LEN_W(LEN_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .written_o  (written_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o)
);

// File: tb/aai_program_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: flash and shifter model with random stalls and busy counts,
// directed and random runs compared against an expected frame list.
module aai_program_seq_tb_top;
    localparam int ADDR_W = 24;
    localparam int LEN_W  = 16;
    localparam int TMO    = 200;
    localparam int HANG   = 1000000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i, byte_mode_i;
    logic [ADDR_W-1:0] addr_i;
    logic [LEN_W-1:0]  len_i;
    logic              busy_o, done_o, err_o;
    logic [LEN_W-1:0]  written_o;
    logic              in_valid_i, in_ready_o;
    logic [7:0]        in_byte_i;
    logic              tx_valid_o, tx_last_o, tx_ready_i;
    logic [7:0]        tx_byte_o;
    logic              rx_valid_i;
    logic [7:0]        rx_byte_i;

    always #2.5 clk = ~clk;

    aai_program_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TIMEOUT_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_mode_i(byte_mode_i),
        .addr_i(addr_i), .len_i(len_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .written_o(written_o), .in_valid_i(in_valid_i),
        .in_byte_i(in_byte_i), .in_ready_o(in_ready_o), .tx_valid_o(tx_valid_o),
        .tx_byte_o(tx_byte_o), .tx_last_o(tx_last_o), .tx_ready_i(tx_ready_i),
        .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0]  dmem [0:63];
    logic [51:0] act_q[$];
    logic [51:0] exp_q[$];
    int sidx = 0, run_len = 0, prog_cnt = 0, hang_idx = 0, busy_left = 0;
    int rx_cnt = -1, cycles = 0;
    logic [47:0] fval = '0;
    int flen = 0;
    bit exp_err;
    int exp_written, exp_cons;

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic string req_of(logic [51:0] f);
        logic [7:0] op;
        int n;
        n  = int'(f[51:48]);
        op = 8'(f[47:0] >> (8 * (n - 1)));
        if (op == 8'h06) return "R2";
        if (op == 8'h04) return "R6";
        if (op == 8'h02) return "R7";
        if (n == 6)      return "R3";
        return "R4";
    endfunction

    // Model-side end of a frame: answer status reads, record others, track flash busy.
    task automatic frame_end();
        logic [7:0] op;
        op = 8'(fval >> (8 * (flen - 1)));
        if (op == 8'h05) begin
            rx_cnt = 1;
        end else begin
            act_q.push_back({4'(flen), fval});
            check(busy_left == 0, "R5", "frame sent while flash busy", busy_left, 0);
            if (op == 8'h02 || op == 8'hAD) begin
                prog_cnt++;
                busy_left = (prog_cnt == hang_idx) ? HANG : int'($urandom % 4);
            end
        end
        fval = '0;
        flen = 0;
    endtask

    // Shifter, flash and stream model; also the watchdog.
    initial begin
        tx_ready_i = 1'b0; in_valid_i = 1'b0; in_byte_i = '0;
        rx_valid_i = 1'b0; rx_byte_i = '0;
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
            rx_valid_i = 1'b0;
            if (rx_cnt > 0) rx_cnt--;
            else if (rx_cnt == 0) begin
                rx_valid_i = 1'b1;
                rx_byte_i  = {7'($urandom), busy_left > 0};
                if (busy_left > 0 && busy_left < HANG) busy_left--;
                rx_cnt = -1;
            end
            tx_ready_i = ($urandom % 4) != 0;
            in_valid_i = (sidx < run_len) && (($urandom % 4) != 0);
            in_byte_i  = dmem[sidx % 64];
            #1;
            if (in_valid_i && in_ready_o) sidx++;
            if (tx_valid_o && tx_ready_i) begin
                fval = {fval[39:0], tx_byte_o};
                flen++;
                if (tx_last_o) frame_end();
            end
        end
    end

    task automatic push_f(int n, logic [47:0] v);
        exp_q.push_back({4'(n), v});
    endtask

    // Expected frame list, confirmed bytes and consumed bytes from the requirements.
    task automatic build_exp(logic [23:0] a0, int len, bit bm, int hang);
        logic [23:0] a = a0;
        int r = len, di = 0, pc = 0;
        bit stop = 0;
        exp_q.delete();
        exp_written = 0;
        exp_cons = 0;
        if (bm) begin
            while (r > 0 && !stop) begin
                push_f(1, 48'h06);
                push_f(5, {8'h02, a, dmem[di]});
                exp_cons++; pc++;
                if (pc == hang) stop = 1;
                else begin a++; r--; di++; exp_written++; end
            end
            if (!stop && len > 0) push_f(1, 48'h04);
        end else begin
            if (r > 0 && a[0]) begin
                push_f(1, 48'h06);
                push_f(5, {8'h02, a, dmem[di]});
                exp_cons++; pc++;
                if (pc == hang) stop = 1;
                else begin a++; r--; di++; exp_written++; end
            end
            if (!stop && r >= 2) begin
                push_f(1, 48'h06);
                push_f(6, {8'hAD, a, dmem[di], dmem[di+1]});
                exp_cons += 2; pc++;
                if (pc == hang) stop = 1;
                else begin a += 2; r -= 2; di += 2; exp_written += 2; end
                while (!stop && r >= 2) begin
                    push_f(3, {8'hAD, dmem[di], dmem[di+1]});
                    exp_cons += 2; pc++;
                    if (pc == hang) stop = 1;
                    else begin a += 2; r -= 2; di += 2; exp_written += 2; end
                end
                if (!stop) push_f(1, 48'h04);
            end
            if (!stop && r == 1) begin
                push_f(1, 48'h06);
                push_f(5, {8'h02, a, dmem[di]});
                exp_cons++; pc++;
                if (pc == hang) stop = 1;
                else exp_written++;
            end
        end
        exp_err = stop;
    endtask

    task automatic run_case(logic [23:0] a, int len, bit bm, int hang, bit poke, string tag);
        bit got_err;
        int got_wr;
        int n;
        for (int i = 0; i < 64; i++) dmem[i] = 8'($urandom);
        build_exp(a, len, bm, hang);
        act_q.delete();
        sidx = 0; run_len = len; prog_cnt = 0; hang_idx = hang; busy_left = 0;
        @(negedge clk);
        start_i = 1'b1; addr_i = a; len_i = LEN_W'(len); byte_mode_i = bm;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (8) @(negedge clk);
            start_i = 1'b1; addr_i = a ^ 24'h5; len_i = 3; byte_mode_i = !bm;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        got_err = err_o;
        got_wr  = int'(written_o);
        repeat (30) @(negedge clk);
        check(got_err == exp_err, exp_err ? "R9" : "R10", {tag, " error flag"}, got_err, exp_err);
        check(got_wr == exp_written, exp_err ? "R9" : "R10", {tag, " confirmed bytes"}, got_wr, exp_written);
        check(!busy_o, "R10", {tag, " idle after done"}, busy_o, 0);
        check(act_q.size() == exp_q.size(), "R5", {tag, " frame count"}, act_q.size(), exp_q.size());
        n = (act_q.size() < exp_q.size()) ? act_q.size() : exp_q.size();
        for (int i = 0; i < n; i++)
            check(act_q[i] == exp_q[i], req_of(exp_q[i]), {tag, " frame"}, act_q[i], exp_q[i]);
        check(sidx == exp_cons, "R11", {tag, " bytes taken from stream"}, sidx, exp_cons);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start_i = 1'b0; byte_mode_i = 1'b0; addr_i = '0; len_i = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !err_o, "R1", "reset flags", {busy_o, done_o, err_o}, 0);
        check(!tx_valid_o && !in_ready_o, "R1", "reset ports", {tx_valid_o, in_ready_o}, 0);
        check(written_o == '0, "R1", "reset count", written_o, 0);

        run_case(24'h000100, 8, 0, 0, 0, "R3 even word run");
        run_case(24'h000101, 7, 0, 0, 0, "R2 odd lead");
        run_case(24'h000201, 6, 0, 0, 0, "R7 lead and trail");
        run_case(24'h000300, 5, 0, 0, 0, "R6 word then trail");
        run_case(24'h000400, 1, 0, 0, 0, "R2 single even");
        run_case(24'h000401, 1, 0, 0, 0, "R2 single odd");
        run_case(24'h000500, 0, 0, 0, 0, "R10 zero length");
        run_case(24'h00FFFF, 4, 0, 0, 0, "R4 address carry");
        run_case(24'h000601, 5, 1, 0, 0, "R8 byte mode");
        run_case(24'h000700, 0, 1, 0, 0, "R8 byte mode zero");
        run_case(24'h000800, 9, 0, 3, 0, "R9 word timeout");
        run_case(24'h000901, 4, 1, 1, 0, "R9 byte timeout");
        run_case(24'h000A01, 6, 0, 1, 0, "R9 lead timeout");
        run_case(24'h000B00, 10, 0, 0, 1, "R12 start while busy");
        for (int k = 0; k < 20; k++)
            run_case(24'($urandom), int'($urandom % 13), bit'($urandom % 2), 0, 0, "R11 random");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule